// File: doc/BRIEF.md
# Three-Phase Carrier PWM Modulator

This block turns three signed phase-to-ground voltage commands into complementary gate drive for three inverter legs. Every phase command is first clipped to half the DC-link voltage in either direction. It is then scaled by a supplied fixed-point reciprocal of that voltage, shifted by one half into a unipolar range, and multiplied by the carrier peak. The result is a compare value between zero and the peak. All three compare values are matched against one shared symmetric triangle carrier.

The same carrier paces the rest of the control loop. The block emits a sampling strobe at each carrier valley and a control-execution strobe a fixed number of cycles after it. It emits a compare-update strobe at each carrier peak. New compare values are taken into shadow registers only at the peak. The low-side output of each leg is the complement of the high-side output, with a programmable blanking gap on both edges.

Top module: `pwm3_modulator`

## Requirements
- R1: The carrier counts up one step per clock from 0 to the active peak, then back down to 0, so one period lasts 2×peak cycles. The active peak is loaded from `carrier_peak` only when the carrier is at 0, and a requested peak below `EXEC_OFS`+2 (10 by default) is raised to that minimum.
- R2: `samp_stb`, `upd_stb` and `exec_stb` are each high for exactly one cycle per carrier period. `upd_stb` comes peak cycles after `samp_stb`, `exec_stb` comes `EXEC_OFS` (8) cycles after `samp_stb`, and the next `samp_stb` comes 2×peak cycles after it.
- R3: With the command inside its limits, the compare value is floor(u×peak/65536). Here u = cmd×recip + 32768, clamped to the range 0 to 65536, and `vdc_recip` is the reciprocal of the DC-link voltage in unsigned Q0.16 (65536/vdc).
- R4: A command above floor(vdc/2) or below −floor(vdc/2) is replaced by that bound before scaling, so it gives the same compare value as the bound itself.
- R5: Bit i of `gate_hi` is high while compare value i exceeds the carrier, delayed by one register stage. With a zero dead time it is high for 2×cmp−1 cycles per period (0 when cmp is 0), and `gate_lo` bit i is its exact complement. Bits 0, 1 and 2 belong to commands a, b and c.
- R6: A compare value changes only on the clock edge at the carrier peak. A command change made during the rising half of the carrier has no effect on the gates until the next peak.
- R7: With `dead_cycles` = N > 0, both gate outputs of a leg are low for N cycles after every change of the raw comparison. The high-side time per period shrinks by N, and the high and low outputs of a leg are never high together.
- R8: While `rst_n` is low, all gate outputs and strobes are low and the carrier sits at 0, counting up. After release, with zero commands and zero compare values, every low-side output turns on at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| v_cmd_a | input | 16 | Signed phase-to-ground voltage command, leg a |
| v_cmd_b | input | 16 | Signed phase-to-ground voltage command, leg b |
| v_cmd_c | input | 16 | Signed phase-to-ground voltage command, leg c |
| vdc | input | 16 | DC-link voltage, same units as the commands |
| vdc_recip | input | 16 | Reciprocal of vdc, unsigned Q0.16 |
| carrier_peak | input | 16 | Requested carrier peak count |
| dead_cycles | input | 8 | Blanking gap in clock cycles |
| gate_hi | output | 3 | High-side gate per leg (bit 0 = a) |
| gate_lo | output | 3 | Low-side gate per leg (bit 0 = a) |
| samp_stb | output | 1 | Sampling strobe at the carrier valley |
| exec_stb | output | 1 | Control-execution strobe |
| upd_stb | output | 1 | Compare-update strobe at the carrier peak |

## Verification
Each strobe appears one cycle after the carrier reaches its point. A new peak takes effect at the next valley. A new command reaches the gates only after the next peak load, and the gates then lag the carrier by one register. After any change of command, peak or dead time, the bench therefore lets three update strobes pass before it counts. It then tallies gate levels over exactly 2×peak cycles, a whole period in which the compare value cannot change. Strobe spacing is measured from one sampling strobe to the next, and the shadow check counts high-side cycles during the rising half that follows a command change made right after a sampling strobe.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic {
        CAR_UP = 1'b0,
        CAR_DN = 1'b1
    } car_dir_e;

    localparam int NUM_LEGS = 3;

endpackage

// File: rtl/pwm3_tri_carrier.sv
module pwm3_tri_carrier
    import pwm3_pkg::*;
#(
    parameter int DW       = 16,
    parameter int EXEC_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] peak_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] pk_o,
    output logic          at_peak_o,
    output logic          samp_o,
    output logic          exec_o,
    output logic          upd_o
);

    localparam logic [DW-1:0] PK_MIN_V = DW'(EXEC_OFS + 2);
    localparam logic [DW-1:0] EXEC_V   = DW'(EXEC_OFS);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] pk;
        car_dir_e      dir;
        logic          samp;
        logic          exec;
        logic          upd;
    } car_t;

    car_t r_q, r_d;
    logic valley_w, top_w;

    always_comb begin
        r_d      = r_q;
        valley_w = (r_q.cnt == '0);
        top_w    = (r_q.cnt == r_q.pk);

        if (valley_w) begin
            r_d.pk = (peak_i < PK_MIN_V) ? PK_MIN_V : peak_i;
        end

        if (r_q.dir == CAR_UP) begin
            if (r_q.cnt >= r_q.pk) begin
                r_d.dir = CAR_DN;
                r_d.cnt = r_q.cnt - 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            if (valley_w) begin
                r_d.dir = CAR_UP;
                r_d.cnt = DW'(1);
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end

        r_d.samp = valley_w;
        r_d.upd  = top_w;
        r_d.exec = (r_q.dir == CAR_UP) && (r_q.cnt == EXEC_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt  <= '0;
            r_q.pk   <= PK_MIN_V;
            r_q.dir  <= CAR_UP;
            r_q.samp <= 1'b0;
            r_q.exec <= 1'b0;
            r_q.upd  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o     = r_q.cnt;
    assign pk_o      = r_q.pk;
    assign at_peak_o = top_w;
    assign samp_o    = r_q.samp;
    assign exec_o    = r_q.exec;
    assign upd_o     = r_q.upd;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= r_q.pk); // R1
    AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.dir == CAR_UP && r_q.cnt == r_q.pk) |=> (r_q.dir == CAR_DN)); // R1
    AST_PK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0) |=> $stable(r_q.pk)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.samp, r_q.exec, r_q.upd})); // R2
    AST_SAMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.samp |=> !r_q.samp); // R2

endmodule

// File: rtl/pwm3_cmp_scaler.sv
module pwm3_cmp_scaler #(
    parameter int DW = 16,
    parameter int RW = 16
) (
    input  logic signed [DW-1:0] cmd_i,
    input  logic        [DW-1:0] vdc_i,
    input  logic        [RW-1:0] recip_i,
    input  logic        [DW-1:0] pk_i,
    output logic        [DW-1:0] cmp_o
);

    localparam int PW = DW + RW + 2;
    localparam int SW = RW + 1 + DW;
    localparam logic signed [PW-1:0] HALF_V  = PW'(2 ** (RW - 1));
    localparam logic signed [PW-1:0] ONE_V   = PW'(2 ** RW);
    localparam logic        [RW:0]   ONE_U   = (RW + 1)'(2 ** RW);

    logic signed [DW:0]   cmd_x;
    logic signed [DW:0]   lim_s;
    logic signed [DW:0]   sat_s;
    logic signed [PW-1:0] prod_s;
    logic signed [PW-1:0] bias_s;
    logic        [RW:0]   u_w;
    logic        [SW-1:0] scaled_w;
    logic        [SW-1:0] quot_w;

    always_comb begin
        cmd_x = (DW + 1)'(cmd_i);
        lim_s = $signed({1'b0, (vdc_i >> 1)});

        if (cmd_x > lim_s) begin
            sat_s = lim_s;
        end else if (cmd_x < -lim_s) begin
            sat_s = -lim_s;
        end else begin
            sat_s = cmd_x;
        end

        prod_s = PW'(sat_s) * PW'($signed({1'b0, recip_i}));
        bias_s = prod_s + HALF_V;

        if (bias_s < 0) begin
            u_w = '0;
        end else if (bias_s > ONE_V) begin
            u_w = ONE_U;
        end else begin
            u_w = (RW + 1)'(bias_s);
        end

        scaled_w = SW'(u_w) * SW'(pk_i);
        quot_w   = scaled_w >> RW;

        if (quot_w > SW'(pk_i)) begin
            cmp_o = pk_i;
        end else begin
            cmp_o = DW'(quot_w);
        end
    end

endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            hs_o,
    output logic            ls_o
);

    typedef struct packed {
        logic            raw;
        logic [DT_W-1:0] dly;
        logic            hs;
        logic            ls;
    } db_t;

    db_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (raw_i != r_q.raw) begin
            r_d.raw = raw_i;
            if (dt_i == '0) begin
                r_d.dly = '0;
                r_d.hs  = raw_i;
                r_d.ls  = !raw_i;
            end else begin
                r_d.dly = dt_i - 1'b1;
                r_d.hs  = 1'b0;
                r_d.ls  = 1'b0;
            end
        end else if (r_q.dly != '0) begin
            r_d.dly = r_q.dly - 1'b1;
            r_d.hs  = 1'b0;
            r_d.ls  = 1'b0;
        end else begin
            r_d.hs = r_q.raw;
            r_d.ls = !r_q.raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_o = r_q.hs;
    assign ls_o = r_q.ls;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.hs && r_q.ls)); // R7
    AST_GAP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.hs) && dt_i != '0) |-> !r_q.ls); // R7
    AST_GAP_AFTER_LS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.ls) && dt_i != '0) |-> !r_q.hs); // R7

endmodule

// File: rtl/pwm3_modulator.sv
module pwm3_modulator
    import pwm3_pkg::*;
#(
    parameter int DW       = 16,
    parameter int RW       = 16,
    parameter int DT_W     = 8,
    parameter int EXEC_OFS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DW-1:0]     v_cmd_a,
    input  logic signed [DW-1:0]     v_cmd_b,
    input  logic signed [DW-1:0]     v_cmd_c,
    input  logic        [DW-1:0]     vdc,
    input  logic        [RW-1:0]     vdc_recip,
    input  logic        [DW-1:0]     carrier_peak,
    input  logic        [DT_W-1:0]   dead_cycles,
    output logic        [NUM_LEGS-1:0] gate_hi,
    output logic        [NUM_LEGS-1:0] gate_lo,
    output logic                     samp_stb,
    output logic                     exec_stb,
    output logic                     upd_stb
);

    localparam int NL = NUM_LEGS;

    typedef struct packed {
        logic [NL-1:0][DW-1:0] cmp;
    } shd_t;

    shd_t r_q, r_d;

    logic [DW-1:0] cnt_w;
    logic [DW-1:0] pk_w;
    logic          load_w;
    logic [NL-1:0] raw_w;
    logic signed [DW-1:0] cmd_w [NL];
    logic [DW-1:0] cmp_nx [NL];

    assign cmd_w[0] = v_cmd_a;
    assign cmd_w[1] = v_cmd_b;
    assign cmd_w[2] = v_cmd_c;

    pwm3_tri_carrier #(
        .DW       (DW),
        .EXEC_OFS (EXEC_OFS)
    ) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .peak_i    (carrier_peak),
        .cnt_o     (cnt_w),
        .pk_o      (pk_w),
        .at_peak_o (load_w),
        .samp_o    (samp_stb),
        .exec_o    (exec_stb),
        .upd_o     (upd_stb)
    );

    always_comb begin
        r_d = r_q;
        if (load_w) begin
            for (int k = 0; k < NL; k++) begin
                r_d.cmp[k] = cmp_nx[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_leg
        pwm3_cmp_scaler #(
            .DW (DW),
            .RW (RW)
        ) u_scl (
            .cmd_i   (cmd_w[g]),
            .vdc_i   (vdc),
            .recip_i (vdc_recip),
            .pk_i    (pk_w),
            .cmp_o   (cmp_nx[g])
        );

        assign raw_w[g] = (r_q.cmp[g] > cnt_w);

        pwm3_deadband #(
            .DT_W (DT_W)
        ) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_w[g]),
            .dt_i  (dead_cycles),
            .hs_o  (gate_hi[g]),
            .ls_o  (gate_lo[g])
        );

        AST_CMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_nx[g] <= pk_w); // R3
        AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(load_w) |-> $stable(r_q.cmp[g])); // R6
    end

endmodule

// File: tb/tb_pwm3_modulator.sv
module tb_pwm3_modulator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic signed [15:0] cmd_a, cmd_b, cmd_c;
    logic [15:0] vdc, recip, peak;
    logic [7:0]  dead;
    logic [2:0]  ghi, glo;
    logic        samp, exec, upd;

    int n_vec = 0;
    int n_bad = 0;
    int nh [3];
    int nl [3];
    int nz [3];

    pwm3_modulator dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .v_cmd_a      (cmd_a),
        .v_cmd_b      (cmd_b),
        .v_cmd_c      (cmd_c),
        .vdc          (vdc),
        .vdc_recip    (recip),
        .carrier_peak (peak),
        .dead_cycles  (dead),
        .gate_hi      (ghi),
        .gate_lo      (glo),
        .samp_stb     (samp),
        .exec_stb     (exec),
        .upd_stb      (upd)
    );

    typedef struct packed {
        logic signed [15:0] ca;
        logic signed [15:0] cb;
        logic signed [15:0] cc;
        logic [15:0] v;
        logic [15:0] rc;
        logic [15:0] pk;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [15:0] ec;
    } vec_t;

    // Expected compare values per leg (R3, R4)
    localparam vec_t VECS [5] = '{
        '{16'sd0,   16'sd100,   -16'sd150,   16'd400, 16'd163, 16'd100,  16'd50,  16'd74,  16'd12},
        '{16'sd200, 16'sd1000,  -16'sd32768, 16'd400, 16'd163, 16'd100,  16'd99,  16'd99,  16'd0},
        '{16'sd200, -16'sd200,  16'sd0,      16'd400, 16'd164, 16'd100,  16'd100, 16'd0,   16'd50},
        '{16'sd300, -16'sd300,  16'sd150,    16'd600, 16'd109, 16'd100,  16'd99,  16'd0,   16'd74},
        '{16'sd0,   16'sd100,   -16'sd150,   16'd400, 16'd163, 16'd1000, 16'd500, 16'd748, 16'd126}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cmd_a = v.ca;
        cmd_b = v.cb;
        cmd_c = v.cc;
        vdc   = v.v;
        recip = v.rc;
        peak  = v.pk;
    endtask

    task automatic wait_upd(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!upd);
        end
    endtask

    task automatic wait_samp();
        do @(negedge clk); while (!samp);
    endtask

    task automatic measure(input int n);
        for (int p = 0; p < 3; p++) begin
            nh[p] = 0; nl[p] = 0; nz[p] = 0;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                nh[p] += int'(ghi[p]);
                nl[p] += int'(glo[p]);
                nz[p] += int'(!ghi[p] && !glo[p]);
            end
        end
    endtask

    function automatic int hs_cnt(input int c);
        return (c == 0) ? 0 : 2 * c - 1;
    endfunction

    // strobe spacing over one period starting at a sampling strobe
    task automatic strobe_period(output int t_exec, output int t_upd, output int t_samp,
                                 output int n_exec, output int n_upd);
        int k;
        k = 0; t_exec = -1; t_upd = -1; t_samp = -1; n_exec = 0; n_upd = 0;
        wait_samp();
        while (t_samp < 0 && k < 5000) begin
            @(negedge clk);
            k++;
            if (exec) begin n_exec++; if (t_exec < 0) t_exec = k; end
            if (upd)  begin n_upd++;  if (t_upd  < 0) t_upd  = k; end
            if (samp) t_samp = k;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got 0 expected 1 (run did not complete)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int te, tu, ts, ne, nu;
        cmd_a = 0; cmd_b = 0; cmd_c = 0;
        vdc = 16'd400; recip = 16'd163; peak = 16'd100; dead = 8'd0;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "gate_hi in reset", int'(ghi), 0);
        check("R8", "gate_lo in reset", int'(glo), 0);
        check("R8", "strobes in reset", int'({samp, exec, upd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "gate_lo after first edge", int'(glo), 7);
        check("R8", "gate_hi after first edge", int'(ghi), 0);

        // Vector table: R3, R4, R5
        for (int i = 0; i < 5; i++) begin
            int pk;
            int ex [3];
            apply(VECS[i]);
            pk = int'(VECS[i].pk);
            ex[0] = int'(VECS[i].ea);
            ex[1] = int'(VECS[i].eb);
            ex[2] = int'(VECS[i].ec);
            wait_upd(3);
            measure(2 * pk);
            for (int p = 0; p < 3; p++) begin
                check((i == 1 || i == 3) ? "R4" : "R3", $sformatf("vec %0d leg %0d hi", i, p),
                      nh[p], hs_cnt(ex[p]));
                check("R5", $sformatf("vec %0d leg %0d lo", i, p), nl[p], 2 * pk - hs_cnt(ex[p]));
                check("R5", $sformatf("vec %0d leg %0d both-off", i, p), nz[p], 0);
            end
        end

        // R2: strobe spacing at peak 100
        apply(VECS[0]);
        wait_upd(3);
        strobe_period(te, tu, ts, ne, nu);
        check("R2", "samp to exec", te, 8);
        check("R2", "samp to upd", tu, 100);
        check("R2", "samp to samp", ts, 200);
        check("R2", "exec pulses per period", ne, 1);
        check("R2", "upd pulses per period", nu, 1);

        // R1: new peak adopted only at the next valley
        wait_samp();
        peak = 16'd60;
        ts = 0;
        do begin @(negedge clk); ts++; end while (!samp);
        check("R1", "period after mid-cycle peak change", ts, 200);
        ts = 0;
        do begin @(negedge clk); ts++; end while (!samp);
        check("R1", "period with new peak", ts, 120);

        // R1: peak below minimum raised to 10
        @(negedge clk);
        peak = 16'd3;
        wait_samp();
        wait_samp();
        ts = 0;
        do begin @(negedge clk); ts++; end while (!samp);
        check("R1", "period with clamped peak", ts, 20);

        // R6: command change during rising half is held until peak
        apply(VECS[0]);
        wait_upd(3);
        wait_samp();
        cmd_a = 16'sd200;
        measure(60);
        check("R6", "leg 0 hi during rising half", nh[0], 49);
        wait_upd(3);
        measure(200);
        check("R6", "leg 0 hi after peak load", nh[0], hs_cnt(99));

        // R7: dead time of 5 cycles
        apply(VECS[0]);
        dead = 8'd5;
        wait_upd(3);
        measure(200);
        check("R7", "leg 0 hi with gap", nh[0], hs_cnt(50) - 5);
        check("R7", "leg 0 lo with gap", nl[0], 200 - hs_cnt(50) - 5);
        check("R7", "leg 0 both-off", nz[0], 10);
        check("R7", "leg 1 both-off", nz[1], 10);
        check("R7", "leg 2 hi with gap", nh[2], hs_cnt(12) - 5);
        check("R7", "leg 2 both-off", nz[2], 10);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule